// File: doc/BRIEF.md
# Radix-2² Delay-Feedback FFT Stage

This block is one stage of a pipelined FFT built from two cascaded delay-feedback butterflies. Complex fixed-point samples arrive one per accepted handshake. A sample counter, wrapping every N accepted samples, drives both butterflies. Its top bit selects the mode of the first butterfly, whose feedback line is N/2 samples long. Its next bit selects the mode of the second butterfly, whose feedback line is N/4 samples long. Between the two, a multiply by -j is applied by swapping the real and imaginary parts. Each butterfly adder grows the word by one integer bit. The final word is cut down to the output width by truncating each part's magnitude and then restoring its sign.

The input is a ready/valid stream. So is the output, which sits in one register. A sample is accepted when `in_valid` and `in_ready` are both high at a clock edge. `in_ready` is low only while a valid result waits and `out_ready` is low. A result held under back-pressure does not change. Each accepted sample after priming yields exactly one result. No result is produced without an accepted input.

Top module: `r22_sdf_stage`

## Requirements
- R1: After a synchronous active-high `rst`, `out_valid` is 0 and `in_ready` is 1.
- R2: `out_valid` stays 0 while the first 3N/4 samples after reset are accepted. The (3N/4+1)-th accepted sample gives the first valid result, one cycle after it is accepted.
- R3: Inputs are grouped per N-sample frame. With Q=N/4 and, for each n in 0..Q-1, a=x[n], b=x[n+Q], c=x[n+2Q], d=x[n+3Q], the valid results come in blocks of Q. The blocks cycle in the order a+b+c+d, then a-b+c-d, then (a-c)-j(b-d), then (a-c)+j(b-d), each block indexed by n ascending.
- R4: The internal result is IN_W+2 bits wide. It is reduced to OUT_W bits by dropping IN_W+2-OUT_W LSBs from the magnitude of the real and imaginary parts separately, so each part rounds toward zero. The parts of the input are signed two's complement.
- R5: The -j rotation maps (re, im) to (im, -re). It is applied to the first butterfly's output only while the counter is in the second quarter of its frame.
- R6: `in_ready` is 0 only while `out_valid` is 1 and `out_ready` is 0. A sample is taken only when `in_valid` and `in_ready` are both 1.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_re` and `out_im` hold their values.
- R8: The counter advances only on accepted samples. Idle cycles and stalls leave the result sequence unchanged, and a consumed result without a new input drops `out_valid`.
- R9: A reset in the middle of a stream clears the counter and both delay lines. The stream then primes again as in R2 and produces results per R3 from the new samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Stage can take a sample |
| in_re | input | IN_W | Real part of input, signed |
| in_im | input | IN_W | Imaginary part of input, signed |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_re | output | OUT_W | Real part of result, signed |
| out_im | output | OUT_W | Imaginary part of result, signed |

## Verification
The properties assume the consumer may stall at any time. They also assume that `in_valid` may drop between samples, and that reset is held for at least one edge before any stream starts. The bench drives both pseudo-random gaps in `in_valid` and pseudo-random back-pressure on `out_ready`. The inputs stay within the 12-bit signed range, including runs at both extremes, so the IN_W+2-bit internal word never wraps. A mid-stream reset is issued only between complete handshakes, and the bench restarts its expected-value bookkeeping from the new first sample.

// File: rtl/r22_pkg.sv
package r22_pkg;
  typedef enum logic {
    BF_FILL    = 1'b0,
    BF_COMBINE = 1'b1
  } bf_mode_e;
endpackage

// File: rtl/r22_delay_line.sv
module r22_delay_line #(
  parameter int W     = 13,
  parameter int DEPTH = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic signed [W-1:0] din_re,
  input  logic signed [W-1:0] din_im,
  output logic signed [W-1:0] dout_re,
  output logic signed [W-1:0] dout_im
);
  logic signed [W-1:0] tap_re [DEPTH];
  logic signed [W-1:0] tap_im [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) begin
        tap_re[i] <= '0;
        tap_im[i] <= '0;
      end
    end else if (en) begin
      tap_re[0] <= din_re;
      tap_im[0] <= din_im;
      for (int i = 1; i < DEPTH; i++) begin
        tap_re[i] <= tap_re[i-1];
        tap_im[i] <= tap_im[i-1];
      end
    end
  end

  assign dout_re = tap_re[DEPTH-1];
  assign dout_im = tap_im[DEPTH-1];
endmodule

// File: rtl/r22_butterfly.sv
module r22_butterfly
  import r22_pkg::*;
#(
  parameter int XW    = 12,
  parameter int DEPTH = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  bf_mode_e             mode,
  input  logic signed [XW-1:0] x_re,
  input  logic signed [XW-1:0] x_im,
  output logic signed [XW:0]   y_re,
  output logic signed [XW:0]   y_im
);
  localparam int YW = XW + 1;

  logic signed [YW-1:0] head_re, head_im;
  logic signed [YW-1:0] xe_re, xe_im;
  logic signed [YW-1:0] sum_re, sum_im, dif_re, dif_im;
  logic signed [YW-1:0] push_re, push_im;

  assign xe_re  = YW'(x_re);
  assign xe_im  = YW'(x_im);
  assign sum_re = head_re + xe_re;
  assign sum_im = head_im + xe_im;
  assign dif_re = head_re - xe_re;
  assign dif_im = head_im - xe_im;

  always_comb begin
    if (mode == BF_COMBINE) begin
      y_re    = sum_re;
      y_im    = sum_im;
      push_re = dif_re;
      push_im = dif_im;
    end else begin
      y_re    = head_re;
      y_im    = head_im;
      push_re = xe_re;
      push_im = xe_im;
    end
  end

  r22_delay_line #(.W(YW), .DEPTH(DEPTH)) u_fb (
    .clk    (clk),
    .rst    (rst),
    .en     (en),
    .din_re (push_re),
    .din_im (push_im),
    .dout_re(head_re),
    .dout_im(head_im)
  );
endmodule

// File: rtl/r22_trunc.sv
module r22_trunc #(
  parameter int IW = 14,
  parameter int OW = 12
) (
  input  logic signed [IW-1:0] v,
  output logic signed [OW-1:0] r
);
  localparam int DROP = IW - OW;

  generate
    if (DROP == 0) begin : g_pass
      assign r = v;
    end else begin : g_cut
      logic        neg;
      logic [IW:0] mag, shr, back;
      assign neg  = v[IW-1];
      assign mag  = neg ? -{v[IW-1], v} : {v[IW-1], v};
      assign shr  = mag >> DROP;
      assign back = neg ? -shr : shr;
      assign r    = back[OW-1:0];
    end
  endgenerate
endmodule

// File: rtl/r22_sdf_stage.sv
module r22_sdf_stage
  import r22_pkg::*;
#(
  parameter int N     = 16,
  parameter int IN_W  = 12,
  parameter int OUT_W = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic signed [IN_W-1:0]  in_re,
  input  logic signed [IN_W-1:0]  in_im,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic signed [OUT_W-1:0] out_re,
  output logic signed [OUT_W-1:0] out_im
);
  localparam int LOGN  = $clog2(N);
  localparam int Q     = N / 4;
  localparam int W1    = IN_W + 1;
  localparam int W2    = IN_W + 2;
  localparam logic [LOGN-1:0] PRIME_AT = LOGN'(3 * Q - 1);

  logic            take;
  logic [LOGN-1:0] cnt;
  logic            primed;
  logic            sel_s, sel_t, rot;

  logic signed [W1-1:0]    b1_re, b1_im, x2_re, x2_im;
  logic signed [W2-1:0]    b2_re, b2_im;
  logic signed [OUT_W-1:0] t_re, t_im;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;
  assign sel_s    = cnt[LOGN-1];
  assign sel_t    = cnt[LOGN-2];
  assign rot      = !sel_s && sel_t;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      primed <= 1'b0;
    end else if (take) begin
      cnt <= cnt + 1'b1;
      if (cnt == PRIME_AT) primed <= 1'b1;
    end
  end

  r22_butterfly #(.XW(IN_W), .DEPTH(N/2)) u_bf_half (
    .clk (clk),
    .rst (rst),
    .en  (take),
    .mode(bf_mode_e'(sel_s)),
    .x_re(in_re),
    .x_im(in_im),
    .y_re(b1_re),
    .y_im(b1_im)
  );

  assign x2_re = rot ? b1_im  : b1_re;
  assign x2_im = rot ? -b1_re : b1_im;

  r22_butterfly #(.XW(W1), .DEPTH(Q)) u_bf_quarter (
    .clk (clk),
    .rst (rst),
    .en  (take),
    .mode(bf_mode_e'(sel_t)),
    .x_re(x2_re),
    .x_im(x2_im),
    .y_re(b2_re),
    .y_im(b2_im)
  );

  r22_trunc #(.IW(W2), .OW(OUT_W)) u_cut_re (.v(b2_re), .r(t_re));
  r22_trunc #(.IW(W2), .OW(OUT_W)) u_cut_im (.v(b2_im), .r(t_im));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_re    <= '0;
      out_im    <= '0;
    end else if (take) begin
      out_valid <= primed;
      out_re    <= t_re;
      out_im    <= t_im;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/r22_sdf_stage_checks.sv
module r22_sdf_stage_checks #(
  parameter int N     = 16,
  parameter int IN_W  = 12,
  parameter int OUT_W = 12
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic signed [IN_W-1:0]  in_re,
  input logic signed [IN_W-1:0]  in_im,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic signed [OUT_W-1:0] out_re,
  input logic signed [OUT_W-1:0] out_im
);
  localparam int CW = $clog2(N) + 1;
  localparam logic [CW-1:0] FIRST = CW'(3 * (N / 4) + 1);

  logic [CW-1:0] acc;

  always_ff @(posedge clk) begin
    if (rst) acc <= '0;
    else if (in_valid && in_ready && acc != FIRST) acc <= acc + 1'b1;
  end

  // R2: no result before 3N/4+1 samples have been taken
  assert_no_early_valid_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (acc == FIRST));

  // R6: a new result only follows an accepted sample
  assert_valid_from_take_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(in_valid && in_ready));

  // R7: stalled result is frozen
  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_re) && $stable(out_im)));

  // R8: consumed result with no new sample leaves nothing valid
  assert_drain_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && !in_valid) |=> !out_valid);
endmodule

bind r22_sdf_stage r22_sdf_stage_checks #(.N(N), .IN_W(IN_W), .OUT_W(OUT_W)) u_chk (.*);

// File: tb/r22_sdf_stage_bench.sv
`timescale 1ns/1ps
module r22_sdf_stage_bench;
  localparam int N     = 16;
  localparam int Q     = N / 4;
  localparam int IN_W  = 12;
  localparam int OUT_W = 12;
  localparam int DROP  = IN_W + 2 - OUT_W;
  localparam int MAXS  = 6 * N;

  logic                    clk = 1'b0;
  logic                    rst = 1'b1;
  logic                    in_valid = 1'b0;
  logic                    in_ready;
  logic signed [IN_W-1:0]  in_re = '0;
  logic signed [IN_W-1:0]  in_im = '0;
  logic                    out_valid;
  logic                    out_ready = 1'b1;
  logic signed [OUT_W-1:0] out_re;
  logic signed [OUT_W-1:0] out_im;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  int d_re [MAXS];
  int d_im [MAXS];
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  r22_sdf_stage #(.N(N), .IN_W(IN_W), .OUT_W(OUT_W)) u_r22_sdf_stage (.*);

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int cut(input int v);
    if (v < 0) return -((-v) >>> DROP);
    return v >>> DROP;
  endfunction

  function automatic logic [15:0] step(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  // expected result k of the stream per R3, R4, R5
  task automatic expect_k(input int k, output int er, output int ei);
    int blk, f, w, n, base, ar, ai, br, bi, cr, ci, dr, di, rr, ri;
    blk = k / Q; f = blk / 4; w = blk % 4; n = k % Q;
    base = f * N + n;
    ar = d_re[base];       ai = d_im[base];
    br = d_re[base + Q];   bi = d_im[base + Q];
    cr = d_re[base + 2*Q]; ci = d_im[base + 2*Q];
    dr = d_re[base + 3*Q]; di = d_im[base + 3*Q];
    case (w)
      0: begin rr = ar + br + cr + dr;          ri = ai + bi + ci + di; end
      1: begin rr = ar - br + cr - dr;          ri = ai - bi + ci - di; end
      2: begin rr = ar - cr + (bi - di);        ri = ai - ci - (br - dr); end
      default: begin rr = ar - cr - (bi - di);  ri = ai - ci + (br - dr); end
    endcase
    er = cut(rr); ei = cut(ri);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);
  endtask

  // pattern: 0 ramp, 1 pseudo-random, 2 extremes, 3 imaginary-only
  task automatic fill(input int pattern, input int total);
    for (int i = 0; i < total; i++) begin
      lfsr = step(lfsr);
      case (pattern)
        0: begin d_re[i] = ((i * 37) % 4096) - 2048; d_im[i] = 2047 - ((i * 91) % 4096); end
        1: begin d_re[i] = int'($signed(lfsr[11:0])); lfsr = step(lfsr);
                 d_im[i] = int'($signed(lfsr[11:0])); end
        2: begin d_re[i] = ((i / N) % 2 == 0) ? -2048 : 2047;
                 d_im[i] = ((i / N) % 2 == 0) ? 2047 : -2048; end
        default: begin d_re[i] = 0; d_im[i] = ((i % Q) + 1) * 100 * ((i / Q) % 4 + 1) - 1500; end
      endcase
    end
  endtask

  // runs frames+1 frames through the stage and checks the first frames*N results
  task automatic run_stream(input string name, input int frames, input int pattern,
                            input bit gaps, input bit stalls);
    int total, want, idx, ocnt, guard, er, ei, hr, hi;
    bit seen, hold;
    total = (frames + 1) * N; want = frames * N;
    idx = 0; ocnt = 0; guard = 0; seen = 0; hold = 0; hr = 0; hi = 0;
    fill(pattern, total);
    while (ocnt < want && guard < 20000) begin
      @(negedge clk);
      guard++;
      lfsr = step(lfsr);
      in_valid  = (idx < total) && (!gaps || lfsr[3] || lfsr[7]);
      out_ready = !stalls || lfsr[1] || lfsr[9];
      in_re = IN_W'(d_re[idx < total ? idx : 0]);
      in_im = IN_W'(d_im[idx < total ? idx : 0]);
      #1;
      if (hold) begin
        chk(out_valid == 1'b1, "R7 valid held", int'(out_valid), 1);
        chk(int'(out_re) == hr && int'(out_im) == hi, "R7 data held", int'(out_re), hr);
      end
      hold = out_valid && !out_ready;
      hr = int'(out_re); hi = int'(out_im);
      if (out_valid && !out_ready)
        chk(in_ready == 1'b0, "R6 ready low under stall", int'(in_ready), 0);
      else
        chk(in_ready == 1'b1, "R6 ready high", int'(in_ready), 1);
      if (out_valid && !seen) begin
        seen = 1;
        chk(idx == 3 * Q + 1, "R2 samples before first result", idx, 3 * Q + 1);
      end
      if (!seen && idx > 3 * Q + 1)
        chk(1'b0, "R2 result missing", idx, 3 * Q + 1);
      if (out_valid && out_ready) begin
        expect_k(ocnt, er, ei);
        chk(int'(out_re) == er, {"R3 R4 R5 real ", name}, int'(out_re), er);
        chk(int'(out_im) == ei, {"R3 R4 R5 imag ", name}, int'(out_im), ei);
        ocnt++;
      end
      if (in_valid && in_ready) idx++;
    end
    chk(ocnt == want, {"R8 result count ", name}, ocnt, want);
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b1;
  endtask

  task automatic t_drain();
    // R8: consuming a result with no new sample empties the output
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b1;
    @(negedge clk);
    #1;
    chk(out_valid == 1'b0, "R8 drain without input", int'(out_valid), 0);
  endtask

  task automatic t_mid_reset();
    // R9: partial stream, reset, then a fresh stream primes again
    do_reset();
    fill(1, N);
    for (int i = 0; i < N - 3; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_re = IN_W'(d_re[i]); in_im = IN_W'(d_im[i]);
    end
    do_reset();
    run_stream("R9 after mid reset", 2, 0, 1'b0, 1'b0);
  endtask

  initial begin
    do_reset();
    run_stream("ramp", 2, 0, 1'b0, 1'b0);
    t_drain();
    do_reset();
    run_stream("random", 3, 1, 1'b0, 1'b0);
    do_reset();
    run_stream("extremes R4", 3, 2, 1'b0, 1'b0);
    do_reset();
    run_stream("imag R5", 2, 3, 1'b0, 1'b0);
    do_reset();
    run_stream("gaps R8", 3, 1, 1'b1, 1'b0);
    do_reset();
    run_stream("stalls R7", 3, 1, 1'b0, 1'b1);
    do_reset();
    run_stream("gaps and stalls", 4, 0, 1'b1, 1'b1);
    t_mid_reset();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule